// File: doc/BRIEF.md
# SCSI Initiator Register Interface

This block is the byte-wide register front end of a single-bus SCSI initiator. A host reaches eight registers through a three-bit address with plain write and read strobes. Write-side registers hold the outgoing data byte, an initiator command byte and a target command byte. Together these drive the SCSI control and data lines. A mode byte selects arbitration, DMA, busy monitoring and the end-of-transfer interrupt. Writes to two further addresses start a DMA send or a DMA initiator receive. An external byte mover sees that choice as a two-bit transfer mode and an enable.

Reads return the data lines (or the held outgoing byte while the block drives the bus), register readback, a snapshot of the bus control lines, and a combined status byte. The block watches for a selection handshake and latches the ID of the selected target. It raises an interrupt when the bus phase seen during a DMA request does not match the programmed phase. The byte mover reports the end of a transfer with a one-cycle pulse on `xfer_last_i`. The host strobes carry no back-pressure: every access completes in the cycle it is presented. Read data is combinational from the address. Read side effects take place at the clock edge of a cycle with `host_rd` high.

Top module: `scsi_ireg`

## Requirements
- R1: Writes to address 0 (outgoing byte), 1 (initiator command), 2 (mode), 3 (target command) and 4 (select enable) take effect at the next clock edge. Reads of addresses 1, 2 and 3 return the held byte, and `sel_enable_o` shows the address-4 byte.
- R2: The bus drivers follow the register bits. Initiator command: bit0 enables the data drivers, bit1 ATN, bit2 SEL, bit3 BSY, bit4 ACK. Target command: bit0 I/O, bit1 C/D, bit2 MSG, bit3 REQ. Mode: bit0 drives the arbitration output.
- R3: A write to address 1 latches `target_id_o` and sets `target_id_vld_o`, provided the written byte has both bit3 (BSY) and bit2 (SEL) set and the held byte has SEL set with BSY clear. The ID is the index of the highest set bit in bits 6..0 of the outgoing byte. If those bits are all zero, the valid flag clears instead. Any other write to address 1 leaves the ID alone.
- R4: A write to address 2 that sets bit0 while the held bit0 is clear clears initiator command bit5 (arbitration lost) and sets bit6 (arbitration in progress).
- R5: A write to address 2 with bit1 (DMA) clear returns the transfer mode to idle. It also clears target command bit7 (last byte sent) and the end-of-transfer flag.
- R6: A write to address 5 sets the transfer mode to send (1), and a write to address 7 sets it to initiator receive (2). `xfer_en_o` is high when mode bit1 is set and the transfer mode is not idle.
- R7: A read of address 0 returns the outgoing byte when initiator command bit0 is set, and the live bus data otherwise.
- R8: A read of address 4 returns the bus lines with bit7 BSY, bit6 REQ, bit5 MSG, bit4 C/D, bit3 I/O, bit2 SEL, bit1 ATN, bit0 ACK.
- R9: A read of address 5 returns a status byte. Bit0 is bus ACK. Bit2 is set when bus BSY is low and mode bit2 is set. Bit3 is set when the eight driven control lines equal the bus lines. Bit4 is the interrupt flag. Bit6 is set when bus REQ is high and mode bit1 is set. Bit7 is the end-of-transfer flag. Bits 1 and 5 read 0.
- R10: While bus REQ is high and mode bit1 is set, a bus phase {MSG,C/D,I/O} that differs from target command bits 2..0 sets the interrupt flag at each clock edge. A read strobe at address 7 clears the flag unless a set condition holds in the same cycle.
- R11: A pulse on `xfer_last_i` sets the end-of-transfer flag. It sets target command bit7 when the transfer mode is send. It sets the interrupt flag when mode bit3 is set.
- R12: Reads of addresses 6 and 7 return 0xFF. Writes to address 6 change no register.
- R13: A synchronous active-high reset clears every register, the transfer mode, the target ID, its valid flag and both latched flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe (side effects only) |
| host_rdata | output | 8 | Read data for `host_addr` |
| bus_data_i | input | 8 | SCSI data lines as seen |
| bus_bsy_i | input | 1 | BSY line |
| bus_sel_i | input | 1 | SEL line |
| bus_atn_i | input | 1 | ATN line |
| bus_ack_i | input | 1 | ACK line |
| bus_req_i | input | 1 | REQ line |
| bus_msg_i | input | 1 | MSG line |
| bus_cd_i | input | 1 | C/D line |
| bus_io_i | input | 1 | I/O line |
| drv_data_o | output | 8 | Outgoing data byte |
| drv_data_en_o | output | 1 | Data driver enable |
| drv_bsy_o | output | 1 | Drive BSY |
| drv_sel_o | output | 1 | Drive SEL |
| drv_atn_o | output | 1 | Drive ATN |
| drv_ack_o | output | 1 | Drive ACK |
| drv_req_o | output | 1 | Drive REQ |
| drv_msg_o | output | 1 | Drive MSG |
| drv_cd_o | output | 1 | Drive C/D |
| drv_io_o | output | 1 | Drive I/O |
| drv_arb_o | output | 1 | Arbitration request |
| sel_enable_o | output | 8 | Select-enable byte |
| target_id_o | output | 3 | Latched target ID |
| target_id_vld_o | output | 1 | Target ID valid |
| xfer_mode_o | output | 2 | Transfer mode: 0 idle, 1 send, 2 receive |
| xfer_en_o | output | 1 | Transfer enable to the byte mover |
| xfer_last_i | input | 1 | End-of-transfer pulse from the byte mover |

## Verification
Every piece of held state is visible one clock edge after the access that changes it. Register bytes show through readback and the drive pins. Wrong interrupt or end-of-transfer flags show in status byte bits 4 and 7. A bad selection decode shows on `target_id_o` at once. The harder faults are order dependent: the arbitration edge, the SEL-then-BSY selection order, and a clear of the interrupt racing a live phase mismatch. Each of these is driven from a prior state that makes the wrong choice give a different byte.

// File: rtl/scsi_ireg_pkg.sv
package scsi_ireg_pkg;
  localparam int REG_W = 8;
  localparam int ADR_W = 3;

  typedef enum logic [ADR_W-1:0] {
    A_DATA = 3'd0, A_ICMD = 3'd1, A_MODE = 3'd2, A_TCMD = 3'd3,
    A_SELEN = 3'd4, A_XSEND = 3'd5, A_SPARE = 3'd6, A_XRECV = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    XFER_IDLE = 2'd0, XFER_SEND = 2'd1, XFER_RECV = 2'd2
  } xfer_e;

  // initiator command bits
  localparam int IC_DBUS = 0, IC_ATN = 1, IC_SEL = 2, IC_BSY = 3, IC_ACK = 4;
  localparam int IC_LOST = 5, IC_AIP = 6;
  // mode bits
  localparam int MD_ARB = 0, MD_DMA = 1, MD_MBSY = 2, MD_EOPI = 3;
  // target command bits
  localparam int TC_IO = 0, TC_CD = 1, TC_MSG = 2, TC_REQ = 3, TC_LAST = 7;

  // control lines, packed in bus-status read order
  typedef struct packed {
    logic bsy, req, msg, cd, io, sel, atn, ack;
  } ctl_t;
endpackage

// File: rtl/scsi_msb_index.sv
module scsi_msb_index #(
  parameter int W = 7,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++)
      if (vec[i]) idx = IW'(i);
  end
  assign any = |vec;
endmodule

// File: rtl/scsi_ireg_core.sv
module scsi_ireg_core
  import scsi_ireg_pkg::*;
#(
  parameter int DW = REG_W,
  localparam int IDW = $clog2(DW - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [ADR_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  input  logic             xfer_last,
  output logic [DW-1:0]    odr_q,
  output logic [DW-1:0]    icr_q,
  output logic [DW-1:0]    mode_q,
  output logic [DW-1:0]    tcr_q,
  output logic [DW-1:0]    ser_q,
  output xfer_e            xfer_q,
  output logic [IDW-1:0]   tid_q,
  output logic             tid_vld_q
);
  logic [IDW-1:0] id_next;
  logic           id_any;
  logic           sel_step;

  scsi_msb_index #(.W(DW - 1)) u_idx (
    .vec(odr_q[DW-2:0]), .idx(id_next), .any(id_any)
  );

  // BSY+SEL written while the held byte has SEL alone
  assign sel_step = wdata[IC_BSY] && wdata[IC_SEL] && icr_q[IC_SEL] && !icr_q[IC_BSY];

  always_ff @(posedge clk) begin
    if (rst) begin
      odr_q <= '0; icr_q <= '0; mode_q <= '0; tcr_q <= '0; ser_q <= '0;
      xfer_q <= XFER_IDLE; tid_q <= '0; tid_vld_q <= 1'b0;
    end else begin
      if (xfer_last && xfer_q == XFER_SEND) tcr_q[TC_LAST] <= 1'b1;
      if (wr) begin
        case (addr)
          A_DATA:  odr_q <= wdata;
          A_ICMD: begin
            if (sel_step) begin
              tid_q     <= id_next;
              tid_vld_q <= id_any;
            end
            icr_q <= wdata;
          end
          A_MODE: begin
            if (wdata[MD_ARB] && !mode_q[MD_ARB]) begin
              icr_q[IC_LOST] <= 1'b0;
              icr_q[IC_AIP]  <= 1'b1;
            end
            mode_q <= wdata;
            if (!wdata[MD_DMA]) begin
              tcr_q[TC_LAST] <= 1'b0;
              xfer_q         <= XFER_IDLE;
            end
          end
          A_TCMD:  tcr_q  <= wdata;
          A_SELEN: ser_q  <= wdata;
          A_XSEND: xfer_q <= XFER_SEND;
          A_XRECV: xfer_q <= XFER_RECV;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scsi_irq_flags.sv
module scsi_irq_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_phase,
  input  logic set_eop,
  input  logic eop_int_en,
  input  logic clr_int,
  input  logic clr_eod,
  output logic int_q,
  output logic eod_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= 1'b0;
      eod_q <= 1'b0;
    end else begin
      if (set_phase || (set_eop && eop_int_en)) int_q <= 1'b1;
      else if (clr_int)                        int_q <= 1'b0;
      if (clr_eod)      eod_q <= 1'b0;
      else if (set_eop) eod_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scsi_ireg_status.sv
module scsi_ireg_status
  import scsi_ireg_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic [ADR_W-1:0] addr,
  input  logic [DW-1:0]    odr,
  input  logic [DW-1:0]    icr,
  input  logic [DW-1:0]    mode,
  input  logic [DW-1:0]    tcr,
  input  logic [DW-1:0]    bus_data,
  input  ctl_t             bus,
  input  ctl_t             drv,
  input  logic             int_f,
  input  logic             eod_f,
  output logic             phase_bad,
  output logic [DW-1:0]    rdata
);
  logic          drq;
  logic [DW-1:0] stat;

  assign drq       = bus.req && mode[MD_DMA];
  assign phase_bad = drq && ({bus.msg, bus.cd, bus.io} != tcr[TC_MSG:TC_IO]);

  always_comb begin
    stat    = '0;
    stat[0] = bus.ack;
    stat[2] = !bus.bsy && mode[MD_MBSY];
    stat[3] = (drv == bus);
    stat[4] = int_f;
    stat[6] = drq;
    stat[7] = eod_f;
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = icr[IC_DBUS] ? odr : bus_data;
      A_ICMD:  rdata = icr;
      A_MODE:  rdata = mode;
      A_TCMD:  rdata = tcr;
      A_SELEN: rdata = bus;
      A_XSEND: rdata = stat;
      default: rdata = '1;
    endcase
  end
endmodule

// File: rtl/scsi_ireg.sv
module scsi_ireg
  import scsi_ireg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] host_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  input  logic [7:0] bus_data_i,
  input  logic       bus_bsy_i,
  input  logic       bus_sel_i,
  input  logic       bus_atn_i,
  input  logic       bus_ack_i,
  input  logic       bus_req_i,
  input  logic       bus_msg_i,
  input  logic       bus_cd_i,
  input  logic       bus_io_i,
  output logic [7:0] drv_data_o,
  output logic       drv_data_en_o,
  output logic       drv_bsy_o,
  output logic       drv_sel_o,
  output logic       drv_atn_o,
  output logic       drv_ack_o,
  output logic       drv_req_o,
  output logic       drv_msg_o,
  output logic       drv_cd_o,
  output logic       drv_io_o,
  output logic       drv_arb_o,
  output logic [7:0] sel_enable_o,
  output logic [2:0] target_id_o,
  output logic       target_id_vld_o,
  output logic [1:0] xfer_mode_o,
  output logic       xfer_en_o,
  input  logic       xfer_last_i
);
  logic [7:0] odr_q, icr_q, mode_q, tcr_q;
  xfer_e      xfer_q;
  logic       int_q, eod_q, phase_bad;
  ctl_t       bus_c, drv_c;

  scsi_ireg_core #(.DW(REG_W)) u_core (
    .clk(clk), .rst(rst), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .xfer_last(xfer_last_i), .odr_q(odr_q), .icr_q(icr_q), .mode_q(mode_q),
    .tcr_q(tcr_q), .ser_q(sel_enable_o), .xfer_q(xfer_q),
    .tid_q(target_id_o), .tid_vld_q(target_id_vld_o)
  );

  scsi_irq_flags u_flags (
    .clk(clk), .rst(rst), .set_phase(phase_bad), .set_eop(xfer_last_i),
    .eop_int_en(mode_q[MD_EOPI]),
    .clr_int(host_rd && host_addr == A_XRECV),
    .clr_eod(host_wr && host_addr == A_MODE && !host_wdata[MD_DMA]),
    .int_q(int_q), .eod_q(eod_q)
  );

  assign bus_c = '{bsy: bus_bsy_i, req: bus_req_i, msg: bus_msg_i, cd: bus_cd_i,
                   io: bus_io_i, sel: bus_sel_i, atn: bus_atn_i, ack: bus_ack_i};
  assign drv_c = '{bsy: icr_q[IC_BSY], req: tcr_q[TC_REQ], msg: tcr_q[TC_MSG],
                   cd: tcr_q[TC_CD], io: tcr_q[TC_IO], sel: icr_q[IC_SEL],
                   atn: icr_q[IC_ATN], ack: icr_q[IC_ACK]};

  scsi_ireg_status #(.DW(REG_W)) u_stat (
    .addr(host_addr), .odr(odr_q), .icr(icr_q), .mode(mode_q), .tcr(tcr_q),
    .bus_data(bus_data_i), .bus(bus_c), .drv(drv_c), .int_f(int_q),
    .eod_f(eod_q), .phase_bad(phase_bad), .rdata(host_rdata)
  );

  assign drv_data_o    = odr_q;
  assign drv_data_en_o = icr_q[IC_DBUS];
  assign drv_bsy_o     = drv_c.bsy;
  assign drv_sel_o     = drv_c.sel;
  assign drv_atn_o     = drv_c.atn;
  assign drv_ack_o     = drv_c.ack;
  assign drv_req_o     = drv_c.req;
  assign drv_msg_o     = drv_c.msg;
  assign drv_cd_o      = drv_c.cd;
  assign drv_io_o      = drv_c.io;
  assign drv_arb_o     = mode_q[MD_ARB];
  assign xfer_mode_o   = xfer_q;
  assign xfer_en_o     = mode_q[MD_DMA] && (xfer_q != XFER_IDLE);
endmodule

// File: rtl/scsi_ireg_chk.sv
module scsi_ireg_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] host_addr,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       bus_req_i,
  input logic       bus_msg_i,
  input logic       bus_cd_i,
  input logic       bus_io_i,
  input logic       xfer_last_i,
  input logic [1:0] xfer_mode_o,
  input logic       target_id_vld_o,
  input logic [7:0] odr,
  input logic [7:0] icr,
  input logic [7:0] mode,
  input logic [7:0] tcr,
  input logic       int_f,
  input logic       eod_f
);
  p_sel_latch_r3: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr == 3'd1 && host_wdata[3] && host_wdata[2] &&
    icr[2] && !icr[3] && odr[6:0] != 7'd0 |=> target_id_vld_o);

  p_arb_start_r4: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr == 3'd2 && host_wdata[0] && !mode[0] |=> icr[6] && !icr[5]);

  p_dma_off_r5: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr == 3'd2 && !host_wdata[1] |=> xfer_mode_o == 2'd0 && !eod_f && !tcr[7]);

  p_phase_int_r10: assert property (@(posedge clk) disable iff (rst)
    mode[1] && bus_req_i && {bus_msg_i, bus_cd_i, bus_io_i} != tcr[2:0] |=> int_f);

  p_spare_write_r12: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr == 3'd6 && !xfer_last_i |=>
      $stable(odr) && $stable(icr) && $stable(mode) && $stable(tcr));
endmodule

bind scsi_ireg scsi_ireg_chk u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
  .host_wdata(host_wdata), .bus_req_i(bus_req_i), .bus_msg_i(bus_msg_i),
  .bus_cd_i(bus_cd_i), .bus_io_i(bus_io_i), .xfer_last_i(xfer_last_i),
  .xfer_mode_o(xfer_mode_o), .target_id_vld_o(target_id_vld_o),
  .odr(odr_q), .icr(icr_q), .mode(mode_q), .tcr(tcr_q),
  .int_f(int_q), .eod_f(eod_q)
);

// File: tb/scsi_ireg_test.sv
`timescale 1ns/1ps
module scsi_ireg_test;
  logic       clk = 1'b0, rst = 1'b1;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0, xfer_last_i = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata, bus_data_i = 8'h3C;
  logic bus_bsy_i = 0, bus_sel_i = 0, bus_atn_i = 0, bus_ack_i = 0;
  logic bus_req_i = 0, bus_msg_i = 0, bus_cd_i = 0, bus_io_i = 0;
  logic [7:0] drv_data_o, sel_enable_o;
  logic drv_data_en_o, drv_bsy_o, drv_sel_o, drv_atn_o, drv_ack_o;
  logic drv_req_o, drv_msg_o, drv_cd_o, drv_io_o, drv_arb_o;
  logic [2:0] target_id_o;
  logic       target_id_vld_o, xfer_en_o;
  logic [1:0] xfer_mode_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  scsi_ireg uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic rd_strobe(logic [2:0] a);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  function automatic logic [9:0] drv_vec();
    return {drv_data_en_o, drv_bsy_o, drv_sel_o, drv_atn_o, drv_ack_o,
            drv_req_o, drv_msg_o, drv_cd_o, drv_io_o, drv_arb_o};
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    peek(3'd1, v); chk("R13 icr", v, 0);
    peek(3'd2, v); chk("R13 mode", v, 0);
    peek(3'd3, v); chk("R13 tcr", v, 0);
    chk("R13 drive", drv_vec(), 0);
    chk("R13 id/xfer", {target_id_vld_o, xfer_mode_o, xfer_en_o}, 0);
    peek(3'd5, v); chk("R13 flags", {v[7], v[4]}, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd2, 8'h0C); peek(3'd2, v); chk("R1 mode", v, 8'h0C);
    wr(3'd3, 8'h0F); peek(3'd3, v); chk("R1 tcr", v, 8'h0F);
    wr(3'd1, 8'h1B); peek(3'd1, v); chk("R1 icr", v, 8'h1B);
    wr(3'd4, 8'h81); chk("R1 sel enable", sel_enable_o, 8'h81);
    chk("R2 drive", drv_vec(), 10'b11011_1111_0);
    wr(3'd2, 8'h01); chk("R2 arb", drv_arb_o, 1);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic t_data();
    logic [7:0] v;
    wr(3'd0, 8'hA5); peek(3'd0, v); chk("R7 bus data", v, 8'h3C);
    wr(3'd1, 8'h01); peek(3'd0, v); chk("R7 held byte", v, 8'hA5);
    chk("R2 data out", {drv_data_en_o, drv_data_o}, 9'h1A5);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_select();
    wr(3'd0, 8'h48); wr(3'd1, 8'h04); wr(3'd1, 8'h0C);
    chk("R3 id 6", {target_id_vld_o, target_id_o}, 4'b1110);
    wr(3'd0, 8'h01); wr(3'd1, 8'h0C);
    chk("R3 no latch when BSY held", {target_id_vld_o, target_id_o}, 4'b1110);
    wr(3'd1, 8'h00); wr(3'd1, 8'h0C);
    chk("R3 no latch without SEL first", {target_id_vld_o, target_id_o}, 4'b1110);
    wr(3'd1, 8'h04); wr(3'd1, 8'h0C);
    chk("R3 id 0", {target_id_vld_o, target_id_o}, 4'b1000);
    wr(3'd0, 8'h80); wr(3'd1, 8'h04); wr(3'd1, 8'h0C);
    chk("R3 bit7 ignored", target_id_vld_o, 0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_arb();
    logic [7:0] v;
    wr(3'd1, 8'h20); wr(3'd2, 8'h01); peek(3'd1, v);
    chk("R4 arb rise", v, 8'h40);
    wr(3'd1, 8'h20); wr(3'd2, 8'h01); peek(3'd1, v);
    chk("R4 no rise no change", v, 8'h20);
    wr(3'd2, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic t_xfer();
    logic [7:0] v;
    wr(3'd2, 8'h0A); wr(3'd5, 8'h00);
    chk("R6 send", {xfer_mode_o, xfer_en_o}, 3'b011);
    wr(3'd7, 8'h00);
    chk("R6 recv", {xfer_mode_o, xfer_en_o}, 3'b101);
    wr(3'd5, 8'h00);
    @(negedge clk); xfer_last_i = 1'b1; @(negedge clk); xfer_last_i = 1'b0;
    peek(3'd5, v); chk("R11 eod+int", {v[7], v[4]}, 2'b11);
    peek(3'd3, v); chk("R11 last byte", v[7], 1);
    wr(3'd2, 8'h00);
    chk("R5 idle", {xfer_mode_o, xfer_en_o}, 0);
    peek(3'd5, v); chk("R5 eod clear, int kept", {v[7], v[4]}, 2'b01);
    peek(3'd3, v); chk("R5 last byte clear", v[7], 0);
    rd_strobe(3'd7); peek(3'd5, v); chk("R10 clear by read", v[4], 0);
    wr(3'd2, 8'h02); wr(3'd7, 8'h00);
    @(negedge clk); xfer_last_i = 1'b1; @(negedge clk); xfer_last_i = 1'b0;
    peek(3'd5, v); chk("R11 recv no int", {v[7], v[4]}, 2'b10);
    peek(3'd3, v); chk("R11 recv no last", v[7], 0);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    @(negedge clk); {bus_bsy_i, bus_req_i, bus_msg_i, bus_cd_i, bus_io_i,
                     bus_sel_i, bus_atn_i, bus_ack_i} = 8'b1010_0101;
    peek(3'd4, v); chk("R8 bus byte", v, 8'hA5);
    {bus_bsy_i, bus_req_i, bus_msg_i, bus_cd_i, bus_io_i,
     bus_sel_i, bus_atn_i, bus_ack_i} = 8'h00;
    peek(3'd5, v); chk("R9 match, idle", v, 8'h08);
    wr(3'd2, 8'h04); bus_ack_i = 1'b1;
    peek(3'd5, v); chk("R9 ack+busy err", v, 8'h05);
    bus_ack_i = 1'b0; bus_bsy_i = 1'b1; wr(3'd2, 8'h02); wr(3'd3, 8'h01);
    bus_req_i = 1'b1; bus_io_i = 1'b1;
    @(negedge clk);
    peek(3'd5, v); chk("R9 drq, no int when phase agrees", v, 8'h40);
    bus_io_i = 1'b0; @(negedge clk); @(negedge clk);
    peek(3'd5, v); chk("R10 phase mismatch int", {v[6], v[4]}, 2'b11);
    rd_strobe(3'd7); peek(3'd5, v); chk("R10 set beats clear", v[4], 1);
    bus_req_i = 1'b0; rd_strobe(3'd7);
    peek(3'd5, v); chk("R10 cleared", v[4], 0);
    bus_bsy_i = 1'b0; wr(3'd2, 8'h00); wr(3'd3, 8'h00);
  endtask

  task automatic t_spare();
    logic [7:0] v;
    peek(3'd6, v); chk("R12 read 6", v, 8'hFF);
    peek(3'd7, v); chk("R12 read 7", v, 8'hFF);
    wr(3'd0, 8'h11); wr(3'd1, 8'h12); wr(3'd2, 8'h04); wr(3'd3, 8'h02);
    wr(3'd6, 8'hFF);
    peek(3'd1, v); chk("R12 icr kept", v, 8'h12);
    peek(3'd2, v); chk("R12 mode kept", v, 8'h04);
    peek(3'd3, v); chk("R12 tcr kept", v, 8'h02);
    chk("R12 data kept", drv_data_o, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset(); t_regs(); t_data(); t_select(); t_arb();
    t_xfer(); t_status(); t_spare();
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    t_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule